// File: doc/BRIEF.md
# Clustered Operand Bypass Network

This block picks the two source operands for every ALU lane of an in-order, multi-lane execute stage. Each operand comes from one of three places. The register-file value is the default. A result can also be forwarded from any lane in the memory stage (MX) or the writeback stage (WX), provided that lane matches the operand's register tag. The lanes are split into equal clusters, and each operand multiplexer only sees result buses from lanes in its own cluster plus the register-file value. This keeps the multiplexers narrow and the wiring short.

A result made in a different cluster is not forwarded at all. It reaches a remote consumer only through that consumer's register-file replica. That replica is updated `XDELAY` cycles after the local one (`XDELAY` is 1 or 2).

The block keeps a short window of retired writeback tags so it knows which remote results are still in flight. When the youngest producer of a needed register is remote and not yet visible, the operand's stall flag is raised. The pipeline then holds the consumer until the value arrives through the replica. Operand `2*i` and operand `2*i+1` belong to lane `i`. Lane `i` is in cluster `i / (LANES/CLUSTERS)`.

Top module: `clustered_bypass`

## Requirements
- R1: An operand with no matching valid producer in MX, WX or the retired window takes its `rfData` value and does not stall. This includes the state straight after reset.
- R2: A matching valid MX result from a lane in the consumer's own cluster is forwarded to the operand in the same cycle, with no stall.
- R3: A matching valid WX result from a lane in the consumer's own cluster is forwarded to the operand in the same cycle, with no stall.
- R4: When both stages match, the youngest producer wins. MX wins over WX, and WX wins over the register-file value.
- R5: When several lanes of the same stage match, the highest-numbered lane wins, because it holds the later instruction.
- R6: A source tag of 0 is never forwarded and never stalls. The operand is always its `rfData` value.
- R7: If the youngest matching producer in MX or WX sits in another cluster, `opStall` is 1 for that operand. This holds even if an older own-cluster producer also matches.
- R8: A WX result that has just left the pipeline stays in a retired window for `XDELAY` cycles. During that window:
  - If it is the youngest match and remote, the operand stalls.
  - If it is the youngest match and local, the operand takes `rfData` without stalling.
  - Once the window ends, neither case stalls.
- R9: A producer whose valid bit is 0 is ignored, whatever its tag.
- R10: An active-low reset empties the retired window at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcTag | input | 2*LANES x RW | Register tag of each operand |
| rfData | input | 2*LANES x DW | Register-file replica value for each operand |
| mxValid | input | LANES | Memory-stage lane holds a register result |
| mxDest | input | LANES x RW | Memory-stage destination tag per lane |
| mxData | input | LANES x DW | Memory-stage result per lane |
| wxValid | input | LANES | Writeback-stage lane holds a register result |
| wxDest | input | LANES x RW | Writeback-stage destination tag per lane |
| wxData | input | LANES x DW | Writeback-stage result per lane |
| opData | output | 2*LANES x DW | Selected operand value |
| opStall | output | 2*LANES | Operand waits for a remote result |

## Verification
Almost all of the selection is combinational, so a wrong priority or cluster decode shows up on `opData` or `opStall` in the same cycle as the stimulus. The only stored state is the retired-tag window. A fault there shows one to two cycles later, in one of two ways:
- a stall that lingers or never appears after a remote writeback;
- a stall that survives a reset.

The tests therefore pair each priority and cluster case with a writeback followed by idle cycles, and with a reset placed between a writeback and its consumer.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
  // Widest lane index inside one cluster that the select code can carry.
  localparam int LANE_SEL_W = 4;

  typedef enum logic [1:0] {
    SRC_RF = 2'd0,
    SRC_MX = 2'd1,
    SRC_WX = 2'd2
  } src_e;

  // Strobe bundle from control to datapath, one per operand.
  typedef struct packed {
    src_e                  kind;
    logic [LANE_SEL_W-1:0] lane;   // lane index within the consumer's cluster
    logic                  stall;
  } sel_t;
endpackage

// File: rtl/bypass_ctrl.sv
module bypass_ctrl
  import bypass_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int CLUSTERS = 2,
  parameter int XDELAY   = 1,
  parameter int RW       = 5
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [2*LANES-1:0][RW-1:0]     srcTag,
  input  logic [LANES-1:0]               mxValid,
  input  logic [LANES-1:0][RW-1:0]       mxDest,
  input  logic [LANES-1:0]               wxValid,
  input  logic [LANES-1:0][RW-1:0]       wxDest,
  output sel_t [2*LANES-1:0]             opSel
);
  localparam int OPS    = 2 * LANES;
  localparam int PER_CL = LANES / CLUSTERS;

  // Retired writeback tags; entry 0 is the most recent.
  logic [XDELAY-1:0][LANES-1:0]         histValid;
  logic [XDELAY-1:0][LANES-1:0][RW-1:0] histDest;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histValid <= '0;
      histDest  <= '0;
    end else begin
      histValid[0] <= wxValid;
      histDest[0]  <= wxDest;
      for (int d = 1; d < XDELAY; d++) begin
        histValid[d] <= histValid[d-1];
        histDest[d]  <= histDest[d-1];
      end
    end
  end

  logic [OPS-1:0] stallVec;

  for (genvar k = 0; k < OPS; k++) begin : g_op
    localparam int MY_CL = (k / 2) / PER_CL;
    sel_t selK;

    // Scan oldest to youngest; the last hit is the youngest producer.
    always_comb begin
      logic found, remote, live;
      src_e kind;
      logic [LANE_SEL_W-1:0] lane;
      found  = 1'b0;
      remote = 1'b0;
      kind   = SRC_RF;
      lane   = '0;
      live   = (srcTag[k] != '0);
      for (int d = XDELAY - 1; d >= 0; d--) begin
        for (int l = 0; l < LANES; l++) begin
          if (live && histValid[d][l] && histDest[d][l] == srcTag[k]) begin
            found  = 1'b1;
            remote = ((l / PER_CL) != MY_CL);
            kind   = SRC_RF;
            lane   = '0;
          end
        end
      end
      for (int l = 0; l < LANES; l++) begin
        if (live && wxValid[l] && wxDest[l] == srcTag[k]) begin
          found  = 1'b1;
          remote = ((l / PER_CL) != MY_CL);
          kind   = SRC_WX;
          lane   = LANE_SEL_W'(l % PER_CL);
        end
      end
      for (int l = 0; l < LANES; l++) begin
        if (live && mxValid[l] && mxDest[l] == srcTag[k]) begin
          found  = 1'b1;
          remote = ((l / PER_CL) != MY_CL);
          kind   = SRC_MX;
          lane   = LANE_SEL_W'(l % PER_CL);
        end
      end
      selK.kind  = kind;
      selK.lane  = lane;
      selK.stall = found && remote;
    end

    assign opSel[k]    = selK;
    assign stallVec[k] = selK.stall;
  end

  // Once nothing has been valid in either stage for two cycles, the retired
  // window (at most two deep) is empty and no operand may wait.
  p_drained_no_stall_r8: assert property (@(posedge clk) disable iff (!rstN)
    (mxValid == '0 && wxValid == '0 && $past(wxValid) == '0 &&
     $past(wxValid, 2) == '0) |-> (stallVec == '0));
endmodule

// File: rtl/bypass_dpath.sv
module bypass_dpath
  import bypass_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int CLUSTERS = 2,
  parameter int DW       = 16
) (
  input  sel_t [2*LANES-1:0]             opSel,
  input  logic [2*LANES-1:0][DW-1:0]     rfData,
  input  logic [LANES-1:0][DW-1:0]       mxData,
  input  logic [LANES-1:0][DW-1:0]       wxData,
  output logic [2*LANES-1:0][DW-1:0]     opData
);
  localparam int OPS    = 2 * LANES;
  localparam int PER_CL = LANES / CLUSTERS;

  for (genvar k = 0; k < OPS; k++) begin : g_mux
    localparam int BASE = ((k / 2) / PER_CL) * PER_CL;
    // Only this cluster's result buses reach the mux.
    logic [PER_CL-1:0][DW-1:0] mxLocal, wxLocal;
    assign mxLocal = mxData[BASE +: PER_CL];
    assign wxLocal = wxData[BASE +: PER_CL];

    always_comb begin
      opData[k] = rfData[k];
      if (!opSel[k].stall) begin
        for (int j = 0; j < PER_CL; j++) begin
          if (opSel[k].lane == LANE_SEL_W'(j)) begin
            if (opSel[k].kind == SRC_MX) opData[k] = mxLocal[j];
            if (opSel[k].kind == SRC_WX) opData[k] = wxLocal[j];
          end
        end
      end
    end
  end
endmodule

// File: rtl/clustered_bypass.sv
module clustered_bypass
  import bypass_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int CLUSTERS = 2,
  parameter int XDELAY   = 1,   // 1 or 2
  parameter int RW       = 5,
  parameter int DW       = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [2*LANES-1:0][RW-1:0]     srcTag,
  input  logic [2*LANES-1:0][DW-1:0]     rfData,
  input  logic [LANES-1:0]               mxValid,
  input  logic [LANES-1:0][RW-1:0]       mxDest,
  input  logic [LANES-1:0][DW-1:0]       mxData,
  input  logic [LANES-1:0]               wxValid,
  input  logic [LANES-1:0][RW-1:0]       wxDest,
  input  logic [LANES-1:0][DW-1:0]       wxData,
  output logic [2*LANES-1:0][DW-1:0]     opData,
  output logic [2*LANES-1:0]             opStall
);
  localparam int OPS = 2 * LANES;

  sel_t [OPS-1:0] opSel;

  bypass_ctrl #(.LANES(LANES), .CLUSTERS(CLUSTERS), .XDELAY(XDELAY), .RW(RW)) u_ctrl (
    .clk(clk), .rstN(rstN), .srcTag(srcTag),
    .mxValid(mxValid), .mxDest(mxDest),
    .wxValid(wxValid), .wxDest(wxDest),
    .opSel(opSel)
  );

  bypass_dpath #(.LANES(LANES), .CLUSTERS(CLUSTERS), .DW(DW)) u_dpath (
    .opSel(opSel), .rfData(rfData), .mxData(mxData), .wxData(wxData),
    .opData(opData)
  );

  for (genvar k = 0; k < OPS; k++) begin : g_out
    assign opStall[k] = opSel[k].stall;

    p_zero_tag_r6: assert property (@(posedge clk) disable iff (!rstN)
      (srcTag[k] == '0) |-> (!opStall[k] && opData[k] == rfData[k]));

    p_stall_needs_tag_r7: assert property (@(posedge clk) disable iff (!rstN)
      opStall[k] |-> (srcTag[k] != '0));

    p_stall_has_source_r7: assert property (@(posedge clk) disable iff (!rstN)
      opStall[k] |-> (mxValid != '0 || wxValid != '0 ||
                      $past(wxValid) != '0 || $past(wxValid, 2) != '0));
  end
endmodule

// File: tb/tb_clustered_bypass.sv
`timescale 1ns/1ps
module tb_clustered_bypass;
  localparam int LANES = 4;
  localparam int OPS   = 8;
  localparam int RW    = 5;
  localparam int DW    = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [OPS-1:0][RW-1:0]   srcTag;
  logic [OPS-1:0][DW-1:0]   rfData;
  logic [LANES-1:0]         mxValid, wxValid;
  logic [LANES-1:0][RW-1:0] mxDest, wxDest;
  logic [LANES-1:0][DW-1:0] mxData, wxData;
  logic [OPS-1:0][DW-1:0]   opData;
  logic [OPS-1:0]           opStall;

  always #2.5 clk = ~clk;

  clustered_bypass dut (
    .clk(clk), .rstN(rstN), .srcTag(srcTag), .rfData(rfData),
    .mxValid(mxValid), .mxDest(mxDest), .mxData(mxData),
    .wxValid(wxValid), .wxDest(wxDest), .wxData(wxData),
    .opData(opData), .opStall(opStall)
  );

  // Operand A = operand 0 (lane 0, cluster 0); operand B = operand 5 (lane 2, cluster 1).
  typedef struct packed {
    logic [3:0]        mxV;
    logic [3:0][4:0]   mxD;
    logic [3:0]        wxV;
    logic [3:0][4:0]   wxD;
    logic [4:0]        tagA;
    logic              stA;
    logic [15:0]       expA;
    logic [4:0]        tagB;
    logic              stB;
    logic [15:0]       expB;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{4'b0000, {5'd0,5'd0,5'd0,5'd0},   4'b0000, {5'd0,5'd0,5'd0,5'd0},   5'd3,  1'b0, 16'hC000, 5'd3,  1'b0, 16'hC005},
    '{4'b0010, {5'd0,5'd0,5'd3,5'd0},   4'b0000, {5'd0,5'd0,5'd0,5'd0},   5'd3,  1'b0, 16'hA001, 5'd3,  1'b1, 16'h0000},
    '{4'b1000, {5'd9,5'd0,5'd0,5'd0},   4'b0001, {5'd0,5'd0,5'd0,5'd7},   5'd7,  1'b0, 16'hB000, 5'd9,  1'b0, 16'hA003},
    '{4'b1001, {5'd6,5'd0,5'd0,5'd4},   4'b0110, {5'd0,5'd6,5'd4,5'd0},   5'd4,  1'b0, 16'hA000, 5'd6,  1'b0, 16'hA003},
    '{4'b0011, {5'd0,5'd0,5'd5,5'd5},   4'b1100, {5'd8,5'd8,5'd0,5'd0},   5'd5,  1'b0, 16'hA001, 5'd8,  1'b0, 16'hB003},
    '{4'b1111, {5'd0,5'd0,5'd0,5'd0},   4'b1111, {5'd0,5'd0,5'd0,5'd0},   5'd0,  1'b0, 16'hC000, 5'd0,  1'b0, 16'hC005},
    '{4'b0100, {5'd0,5'd11,5'd0,5'd0},  4'b0001, {5'd0,5'd0,5'd0,5'd11},  5'd11, 1'b1, 16'h0000, 5'd11, 1'b0, 16'hA002},
    '{4'b0010, {5'd0,5'd0,5'd12,5'd0},  4'b1000, {5'd12,5'd0,5'd0,5'd0},  5'd12, 1'b0, 16'hA001, 5'd12, 1'b1, 16'h0000},
    '{4'b0000, {5'd0,5'd0,5'd13,5'd0},  4'b0000, {5'd0,5'd13,5'd0,5'd0},  5'd13, 1'b0, 16'hC000, 5'd13, 1'b0, 16'hC005},
    '{4'b0101, {5'd0,5'd14,5'd0,5'd14}, 4'b0000, {5'd0,5'd0,5'd0,5'd0},   5'd14, 1'b1, 16'h0000, 5'd14, 1'b0, 16'hA002}
  };

  function automatic string reqOf(int i);
    case (i)
      0: return "R1";          // nothing matches
      1: return "R2/R7";       // local MX for A, remote MX for B
      2: return "R3/R2";       // local WX for A, local MX for B
      3: return "R4";          // MX beats WX
      4: return "R5";          // later lane wins in a stage
      5: return "R6";          // register 0
      6: return "R7";          // young remote beats old local
      7: return "R4/R7";       // young local beats old remote
      8: return "R9";          // invalid producers
      default: return "R5/R7"; // later remote lane in MX
    endcase
  endfunction

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    mxValid = '0; wxValid = '0; mxDest = '0; wxDest = '0;
  endtask

  initial begin
    for (int k = 0; k < OPS; k++) rfData[k] = 16'hC000 + 16'(k);
    for (int l = 0; l < LANES; l++) begin
      mxData[l] = 16'hA000 + 16'(l);
      wxData[l] = 16'hB000 + 16'(l);
    end
    srcTag = '0;
    idle();

    // Reset state (R1)
    repeat (3) @(negedge clk);
    srcTag[0] = 5'd3; srcTag[5] = 5'd3;
    #1;
    chk("R1", "reset opStall", 16'(opStall), 16'h0000);
    chk("R1", "reset op0", opData[0], 16'hC000);
    @(negedge clk);
    rstN = 1'b1;

    // Table walk; each vector starts from a drained retired window.
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); idle(); srcTag = '0;
      repeat (3) @(negedge clk);
      mxValid = VEC[i].mxV; mxDest = VEC[i].mxD;
      wxValid = VEC[i].wxV; wxDest = VEC[i].wxD;
      srcTag[0] = VEC[i].tagA; srcTag[5] = VEC[i].tagB;
      #1;
      chk(reqOf(i), $sformatf("vec%0d stall A", i), 16'(opStall[0]), 16'(VEC[i].stA));
      if (!VEC[i].stA) chk(reqOf(i), $sformatf("vec%0d data A", i), opData[0], VEC[i].expA);
      chk(reqOf(i), $sformatf("vec%0d stall B", i), 16'(opStall[5]), 16'(VEC[i].stB));
      if (!VEC[i].stB) chk(reqOf(i), $sformatf("vec%0d data B", i), opData[5], VEC[i].expB);
      // Tag-0 operands stay on the register file (R6)
      chk("R6", $sformatf("vec%0d op3", i), opData[3], 16'hC003);
    end

    // Retired window with XDELAY = 1 (R8)
    @(negedge clk); idle(); srcTag = '0;
    repeat (3) @(negedge clk);
    wxValid = 4'b1000; wxDest[3] = 5'd20;
    srcTag[0] = 5'd20; srcTag[5] = 5'd20;
    #1;
    chk("R7", "remote WX stall A", 16'(opStall[0]), 16'h0001);
    chk("R3", "local WX data B", opData[5], 16'hB003);
    @(negedge clk); idle();
    #1;
    chk("R8", "retired remote stall A", 16'(opStall[0]), 16'h0001);
    chk("R8", "retired local stall B", 16'(opStall[5]), 16'h0000);
    chk("R8", "retired local data B", opData[5], 16'hC005);
    @(negedge clk);
    #1;
    chk("R8", "window over stall A", 16'(opStall[0]), 16'h0000);
    chk("R8", "window over data A", opData[0], 16'hC000);

    // Reset empties the window (R10)
    @(negedge clk);
    wxValid = 4'b1000; wxDest[3] = 5'd21; srcTag[0] = 5'd0;
    @(negedge clk);
    idle(); rstN = 1'b0; srcTag[0] = 5'd21;
    #1;
    chk("R10", "reset clears window stall A", 16'(opStall[0]), 16'h0000);
    chk("R10", "reset clears window data A", opData[0], 16'hC000);
    @(negedge clk); rstN = 1'b1;
    #1;
    chk("R10", "after reset stall A", 16'(opStall[0]), 16'h0000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule